// File: doc/BRIEF.md
# Counter Access Permission Checker

This block holds the enable registers that decide which less-privileged modes may read the user-visible counters. The counters are cycle, time, instret and the performance counters 3 to 31. There are up to three enable registers, one each at machine, hypervisor and supervisor level. Each register controls only the implemented mode directly below its own level. Permission therefore passes down through every implemented intermediate level: a mode may read a counter only if every level above it allows that read.

A CSR port reads and writes the three enable registers. Writes are legal only from a privilege level at or above the register's own level. Per-bit masks fix chosen enable bits at zero. Alongside the port, the instruction pipeline presents the current privilege mode and the index of the counter being read. The block answers in the same cycle with an illegal-instruction flag. Parameters select whether U, S and H modes are implemented.

The design has no sequential control. It is built from three register slices, a CSR decode stage and a combinational grant cascade.

Top module: `cnten_guard`

## Requirements
- R1: Bit n of every enable register gates the counter whose index is n. Index 0 is cycle, 1 is time, 2 is instret, and 3..31 are the performance counters. The index input is the low 5 bits of the counter's CSR address.
- R2: A counter read issued in machine mode (priv = 3) is never flagged illegal, whatever the enable registers hold.
- R3: In H-mode (priv = 2), a counter read is legal only when the machine-level enable bit for that counter is set. A read from any mode below machine is illegal while that machine-level bit is clear.
- R4: In S-mode (priv = 1), with H-mode present, a read is legal only if H-mode may read the counter and the hypervisor-level bit is set. With H-mode absent, the machine-level bit alone decides.
- R5: In U-mode (priv = 0), with S-mode present, a read is legal only if S-mode may read the counter and the supervisor-level bit is set.
- R6: Enable bits cleared in a register's write mask are hardwired to zero. Writes to them are ignored, they read back as zero, and lower modes always trap on that counter. The default masks are 0x7FFFFFFF at machine level, 0xFFFFFFFF at hypervisor level and 0xFFFFFFF7 at supervisor level.
- R7: The machine-level register is at CSR address 0x320, the hypervisor-level register at 0x220 and the supervisor-level register at 0x120. Read data is combinational. A legal write takes effect at the next rising clock edge.
- R8: An access to an enable register from a mode below that register's level is flagged illegal. The register's level is address bits [9:8]. Such an access returns zero and leaves the register unchanged.
- R9: An access to an enable register that is not implemented is flagged illegal and returns zero.
- R10: After reset, all enable registers hold zero, so every counter read below machine mode is illegal.
- R11: The counter illegal flag is combinational in the request cycle. It stays low while no counter read is requested.
- R12: Privilege is encoded U = 0, S = 1, H = 2, M = 3. A counter read issued in a mode that is not implemented is illegal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_req | input | 1 | CSR access request this cycle |
| csr_we | input | 1 | Request is a write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data, zero unless the access is a legal one to an implemented enable register |
| csr_illegal | output | 1 | CSR access to an enable register is illegal |
| priv | input | 2 | Current privilege mode |
| cnt_rd | input | 1 | A counter read is being executed |
| cnt_idx | input | 5 | Index of the counter being read |
| cnt_illegal | output | 1 | Counter read must raise an illegal instruction |

## Verification
Every stimulus step drives two instances at once, one with H-mode and one without, so the same inputs show how the cascade depends on the presence of H. A sweep over all 32 indices from H-mode, with an irregular machine-level pattern, catches errors in the bit-to-counter mapping. Single-index reads from S and U, with one bit cleared at a time at each level, show whether each register affects only its own lower mode. CSR writes from modes that are too low, and to bits or registers that are hardwired or absent, are read back from machine mode to confirm they had no effect.

// File: rtl/cnten_pkg.sv
package cnten_pkg;

    localparam int ADDR_W = 12;

    typedef enum logic [1:0] {
        PRV_U = 2'd0,
        PRV_S = 2'd1,
        PRV_H = 2'd2,
        PRV_M = 2'd3
    } prv_e;

    // selection code equals the privilege level that owns the register
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_SUP  = 2'd1,
        SEL_HYP  = 2'd2,
        SEL_MAC  = 2'd3
    } ensel_e;

    localparam logic [ADDR_W-1:0] ADDR_MEN = 12'h320;
    localparam logic [ADDR_W-1:0] ADDR_HEN = 12'h220;
    localparam logic [ADDR_W-1:0] ADDR_SEN = 12'h120;

endpackage

// File: rtl/cnten_reg.sv
module cnten_reg #(
    parameter int           W       = 32,
    parameter logic [W-1:0] KEEP    = '1,
    parameter bit           PRESENT = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    generate
        if (PRESENT) begin : g_flop
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (wr_en) begin
                    q <= wdata & KEEP;
                end
            end
        end else begin : g_absent
            assign q = '0;
        end
    endgenerate

endmodule

// File: rtl/cnten_csr_port.sv
module cnten_csr_port
    import cnten_pkg::*;
#(
    parameter bit HAS_U = 1'b1,
    parameter bit HAS_S = 1'b1,
    parameter bit HAS_H = 1'b1,
    parameter int W     = 32
) (
    input  logic              csr_req,
    input  logic              csr_we,
    input  logic [ADDR_W-1:0] csr_addr,
    input  prv_e              priv,
    input  logic [W-1:0]      men,
    input  logic [W-1:0]      hen,
    input  logic [W-1:0]      sen,
    output logic [W-1:0]      rdata,
    output logic              illegal,
    output logic              we_m,
    output logic              we_h,
    output logic              we_s
);

    ensel_e sel;
    logic   present;
    logic   lvl_ok;
    logic   hit;
    logic   ok;

    always_comb begin
        case (csr_addr)
            ADDR_MEN: sel = SEL_MAC;
            ADDR_HEN: sel = SEL_HYP;
            ADDR_SEN: sel = SEL_SUP;
            default:  sel = SEL_NONE;
        endcase
    end

    always_comb begin
        case (sel)
            SEL_MAC: present = HAS_U;
            SEL_HYP: present = HAS_H;
            SEL_SUP: present = HAS_S;
            default: present = 1'b0;
        endcase
    end

    assign lvl_ok  = 2'(priv) >= 2'(sel);
    assign hit     = csr_req && (sel != SEL_NONE);
    assign ok      = hit && present && lvl_ok;
    assign illegal = hit && !(present && lvl_ok);

    always_comb begin
        rdata = '0;
        if (ok) begin
            case (sel)
                SEL_MAC: rdata = men;
                SEL_HYP: rdata = hen;
                SEL_SUP: rdata = sen;
                default: rdata = '0;
            endcase
        end
    end

    assign we_m = ok && csr_we && (sel == SEL_MAC);
    assign we_h = ok && csr_we && (sel == SEL_HYP);
    assign we_s = ok && csr_we && (sel == SEL_SUP);

endmodule

// File: rtl/cnten_grant.sv
module cnten_grant
    import cnten_pkg::*;
#(
    parameter bit HAS_U = 1'b1,
    parameter bit HAS_S = 1'b1,
    parameter bit HAS_H = 1'b1,
    parameter int W     = 32,
    localparam int IW   = $clog2(W)
) (
    input  logic [W-1:0]  men,
    input  logic [W-1:0]  hen,
    input  logic [W-1:0]  sen,
    input  prv_e          priv,
    input  logic          cnt_rd,
    input  logic [IW-1:0] cnt_idx,
    output logic          cnt_illegal
);

    logic [W-1:0] perm_h;
    logic [W-1:0] perm_s;
    logic [W-1:0] perm_u;
    logic [W-1:0] perm_cur;

    // machine level feeds the first implemented mode below it
    generate
        if (HAS_H) begin : g_h
            assign perm_h = men;
        end else begin : g_no_h
            assign perm_h = '0;
        end

        if (HAS_S && HAS_H) begin : g_s_via_h
            assign perm_s = perm_h & hen;
        end else if (HAS_S) begin : g_s_direct
            assign perm_s = men;
        end else begin : g_no_s
            assign perm_s = '0;
        end

        if (HAS_U && HAS_S) begin : g_u_via_s
            assign perm_u = perm_s & sen;
        end else if (HAS_U && HAS_H) begin : g_u_via_h
            assign perm_u = perm_h;
        end else if (HAS_U) begin : g_u_direct
            assign perm_u = men;
        end else begin : g_no_u
            assign perm_u = '0;
        end
    endgenerate

    always_comb begin
        unique case (priv)
            PRV_M:   perm_cur = '1;
            PRV_H:   perm_cur = perm_h;
            PRV_S:   perm_cur = perm_s;
            PRV_U:   perm_cur = perm_u;
            default: perm_cur = '0;
        endcase
    end

    assign cnt_illegal = cnt_rd && !perm_cur[cnt_idx];

endmodule

// File: rtl/cnten_guard.sv
module cnten_guard
    import cnten_pkg::*;
#(
    parameter bit               HAS_U   = 1'b1,
    parameter bit               HAS_S   = 1'b1,
    parameter bit               HAS_H   = 1'b1,
    parameter int               CNT_W   = 32,
    parameter logic [CNT_W-1:0] M_WMASK = 32'h7FFF_FFFF,
    parameter logic [CNT_W-1:0] H_WMASK = 32'hFFFF_FFFF,
    parameter logic [CNT_W-1:0] S_WMASK = 32'hFFFF_FFF7,
    localparam int              IDX_W   = $clog2(CNT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_req,
    input  logic              csr_we,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic [CNT_W-1:0]  csr_wdata,
    output logic [CNT_W-1:0]  csr_rdata,
    output logic              csr_illegal,
    input  logic [1:0]        priv,
    input  logic              cnt_rd,
    input  logic [IDX_W-1:0]  cnt_idx,
    output logic              cnt_illegal
);

    prv_e             cur_prv;
    logic [CNT_W-1:0] men_q;
    logic [CNT_W-1:0] hen_q;
    logic [CNT_W-1:0] sen_q;
    logic             we_m;
    logic             we_h;
    logic             we_s;

    assign cur_prv = prv_e'(priv);

    cnten_reg #(.W(CNT_W), .KEEP(M_WMASK), .PRESENT(HAS_U)) u_men (
        .clk(clk), .rst_n(rst_n), .wr_en(we_m), .wdata(csr_wdata), .q(men_q)
    );

    cnten_reg #(.W(CNT_W), .KEEP(H_WMASK), .PRESENT(HAS_H)) u_hen (
        .clk(clk), .rst_n(rst_n), .wr_en(we_h), .wdata(csr_wdata), .q(hen_q)
    );

    cnten_reg #(.W(CNT_W), .KEEP(S_WMASK), .PRESENT(HAS_S)) u_sen (
        .clk(clk), .rst_n(rst_n), .wr_en(we_s), .wdata(csr_wdata), .q(sen_q)
    );

    cnten_csr_port #(.HAS_U(HAS_U), .HAS_S(HAS_S), .HAS_H(HAS_H), .W(CNT_W)) u_port (
        .csr_req (csr_req),
        .csr_we  (csr_we),
        .csr_addr(csr_addr),
        .priv    (cur_prv),
        .men     (men_q),
        .hen     (hen_q),
        .sen     (sen_q),
        .rdata   (csr_rdata),
        .illegal (csr_illegal),
        .we_m    (we_m),
        .we_h    (we_h),
        .we_s    (we_s)
    );

    cnten_grant #(.HAS_U(HAS_U), .HAS_S(HAS_S), .HAS_H(HAS_H), .W(CNT_W)) u_grant (
        .men        (men_q),
        .hen        (hen_q),
        .sen        (sen_q),
        .priv       (cur_prv),
        .cnt_rd     (cnt_rd),
        .cnt_idx    (cnt_idx),
        .cnt_illegal(cnt_illegal)
    );

endmodule

// File: rtl/cnten_guard_chk.sv
module cnten_guard_chk #(
    parameter bit               HAS_S   = 1'b1,
    parameter int               CNT_W   = 32,
    parameter logic [CNT_W-1:0] M_WMASK = '1,
    localparam int              IDX_W   = $clog2(CNT_W)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             csr_req,
    input logic             csr_we,
    input logic [11:0]      csr_addr,
    input logic [CNT_W-1:0] csr_rdata,
    input logic             csr_illegal,
    input logic [1:0]       priv,
    input logic             cnt_rd,
    input logic [IDX_W-1:0] cnt_idx,
    input logic             cnt_illegal,
    input logic [CNT_W-1:0] men_q,
    input logic [CNT_W-1:0] hen_q,
    input logic [CNT_W-1:0] sen_q
);

    logic known_addr;
    assign known_addr = (csr_addr == 12'h320) || (csr_addr == 12'h220) || (csr_addr == 12'h120);

    AST_M_ALWAYS_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_rd && priv == 2'd3) |-> !cnt_illegal); // R2

    AST_IDLE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_rd |-> !cnt_illegal); // R11

    AST_NEED_M_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_rd && priv != 2'd3 && !men_q[cnt_idx]) |-> cnt_illegal); // R3

    AST_U_NEED_S_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_S && cnt_rd && priv == 2'd0 && !sen_q[cnt_idx]) |-> cnt_illegal); // R5

    AST_LOW_PRIV_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && known_addr && priv < csr_addr[9:8]) |-> csr_illegal); // R8

    AST_BLOCKED_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && csr_we && csr_illegal) |=> ($stable(men_q) && $stable(hen_q) && $stable(sen_q))); // R8

    AST_WARL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && !csr_illegal && csr_addr == 12'h320) |-> ((csr_rdata & ~M_WMASK) == '0)); // R6

    AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && csr_illegal) |-> (csr_rdata == '0)); // R9

endmodule

bind cnten_guard cnten_guard_chk #(
    .HAS_S(HAS_S), .CNT_W(CNT_W), .M_WMASK(M_WMASK)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .csr_req    (csr_req),
    .csr_we     (csr_we),
    .csr_addr   (csr_addr),
    .csr_rdata  (csr_rdata),
    .csr_illegal(csr_illegal),
    .priv       (priv),
    .cnt_rd     (cnt_rd),
    .cnt_idx    (cnt_idx),
    .cnt_illegal(cnt_illegal),
    .men_q      (men_q),
    .hen_q      (hen_q),
    .sen_q      (sen_q)
);

// File: tb/cnten_guard_bench.sv
module cnten_guard_bench;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] MK_M = 32'h7FFF_FFFF;
    localparam logic [31:0] MK_H = 32'hFFFF_FFFF;
    localparam logic [31:0] MK_S = 32'hFFFF_FFF7;
    localparam logic [1:0]  PU = 2'd0, PS = 2'd1, PH = 2'd2, PM = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_req = 1'b0;
    logic        csr_we = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [1:0]  priv = PM;
    logic        cnt_rd = 1'b0;
    logic [4:0]  cnt_idx = '0;

    logic [31:0] a_rdata, b_rdata;
    logic        a_cill, b_cill, a_nill, b_nill;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench models of the enable registers, config A (H present) and B (H absent)
    logic [31:0] am = '0, ah = '0, as_ = '0;
    logic [31:0] bm = '0, bs = '0;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    cnten_guard #(.HAS_U(1'b1), .HAS_S(1'b1), .HAS_H(1'b1),
                  .M_WMASK(MK_M), .H_WMASK(MK_H), .S_WMASK(MK_S)) u_cnten_guard (
        .clk(clk), .rst_n(rst_n), .csr_req(csr_req), .csr_we(csr_we),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(a_rdata),
        .csr_illegal(a_cill), .priv(priv), .cnt_rd(cnt_rd), .cnt_idx(cnt_idx),
        .cnt_illegal(a_nill)
    );

    cnten_guard #(.HAS_U(1'b1), .HAS_S(1'b1), .HAS_H(1'b0),
                  .M_WMASK(MK_M), .H_WMASK(MK_H), .S_WMASK(MK_S)) u_cnten_guard_noh (
        .clk(clk), .rst_n(rst_n), .csr_req(csr_req), .csr_we(csr_we),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(b_rdata),
        .csr_illegal(b_cill), .priv(priv), .cnt_rd(cnt_rd), .cnt_idx(cnt_idx),
        .cnt_illegal(b_nill)
    );

    function automatic logic exp_ill_a(logic rd, logic [1:0] p, int idx);
        if (!rd) return 1'b0;
        case (p)
            PM:      return 1'b0;
            PH:      return !am[idx];
            PS:      return !(am[idx] && ah[idx]);
            default: return !(am[idx] && ah[idx] && as_[idx]);
        endcase
    endfunction

    function automatic logic exp_ill_b(logic rd, logic [1:0] p, int idx);
        if (!rd) return 1'b0;
        case (p)
            PM:      return 1'b0;
            PH:      return 1'b1;
            PS:      return !bm[idx];
            default: return !(bm[idx] && bs[idx]);
        endcase
    endfunction

    task automatic push(int kind, logic [31:0] exp, string tag);
        item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.tag  = tag;
        sb_q.push_back(it);
    endtask

    task automatic cnt_op(logic rd, logic [1:0] p, int idx, string tag);
        @(posedge clk);
        #1;
        csr_req = 1'b0;
        csr_we  = 1'b0;
        cnt_rd  = rd;
        priv    = p;
        cnt_idx = 5'(idx);
        push(0, 32'(exp_ill_a(rd, p, idx)), tag);
        push(3, 32'(exp_ill_b(rd, p, idx)), tag);
    endtask

    task automatic csr_op(logic [1:0] p, logic we, logic [11:0] a, logic [31:0] wd, string tag);
        logic [1:0]  lvl;
        logic        ok_a, ok_b;
        logic [31:0] rd_a, rd_b;
        @(posedge clk);
        #1;
        cnt_rd    = 1'b0;
        csr_req   = 1'b1;
        csr_we    = we;
        csr_addr  = a;
        csr_wdata = wd;
        priv      = p;
        lvl  = a[9:8];
        ok_a = (p >= lvl);
        ok_b = (p >= lvl) && (a != 12'h220);
        rd_a = '0;
        rd_b = '0;
        if (ok_a) rd_a = (a == 12'h320) ? am : (a == 12'h220) ? ah : as_;
        if (ok_b) rd_b = (a == 12'h320) ? bm : bs;
        push(1, 32'(!ok_a), tag);
        push(4, 32'(!ok_b), tag);
        if (!we) begin
            push(2, rd_a, tag);
            push(5, rd_b, tag);
        end else begin
            if (ok_a) begin
                if (a == 12'h320) am = wd & MK_M;
                else if (a == 12'h220) ah = wd & MK_H;
                else as_ = wd & MK_S;
            end
            if (ok_b) begin
                if (a == 12'h320) bm = wd & MK_M;
                else bs = wd & MK_S;
            end
        end
    endtask

    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t       it;
            logic [31:0] act;
            it = sb_q.pop_front();
            case (it.kind)
                0:       act = 32'(a_nill);
                1:       act = 32'(a_cill);
                2:       act = a_rdata;
                3:       act = 32'(b_nill);
                4:       act = 32'(b_cill);
                default: act = b_rdata;
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10: reset contents and trapping
        csr_op(PM, 1'b0, 12'h320, '0, "R10");
        csr_op(PM, 1'b0, 12'h220, '0, "R10");
        csr_op(PM, 1'b0, 12'h120, '0, "R10");
        for (int i = 0; i < 3; i++) cnt_op(1'b1, PU, i, "R10");
        cnt_op(1'b1, PS, 0, "R10");

        // R2: machine mode always allowed
        cnt_op(1'b1, PM, 0, "R2");
        cnt_op(1'b1, PM, 5, "R2");
        cnt_op(1'b1, PM, 31, "R2");

        // R11: no request, no flag
        cnt_op(1'b0, PU, 0, "R11");
        cnt_op(1'b0, PH, 31, "R11");

        // R7 / R6: write and read back the machine register
        csr_op(PM, 1'b1, 12'h320, 32'hFFFF_FFFF, "R7");
        csr_op(PM, 1'b0, 12'h320, '0, "R6");
        cnt_op(1'b1, PH, 31, "R6");
        cnt_op(1'b1, PH, 30, "R3");

        // R1: index-to-bit mapping sweep
        csr_op(PM, 1'b1, 12'h320, 32'hA5A5_00F5, "R7");
        csr_op(PM, 1'b0, 12'h320, '0, "R7");
        for (int i = 0; i < 32; i++) cnt_op(1'b1, PH, i, "R1");
        for (int i = 0; i < 8; i++) cnt_op(1'b1, PS, i, "R1");

        // R4: hypervisor register gates S-mode; R9 for the absent one
        csr_op(PM, 1'b1, 12'h320, 32'hFFFF_FFFF, "R7");
        csr_op(PH, 1'b1, 12'h220, 32'h0000_0005, "R9");
        csr_op(PM, 1'b0, 12'h220, '0, "R9");
        cnt_op(1'b1, PS, 0, "R4");
        cnt_op(1'b1, PS, 1, "R4");
        cnt_op(1'b1, PS, 2, "R4");
        cnt_op(1'b1, PH, 1, "R3");

        // R8: too-low privilege
        csr_op(PS, 1'b1, 12'h220, 32'hFFFF_FFFF, "R8");
        csr_op(PM, 1'b0, 12'h220, '0, "R8");
        csr_op(PU, 1'b0, 12'h120, '0, "R8");
        csr_op(PH, 1'b1, 12'h320, 32'h0, "R8");
        csr_op(PM, 1'b0, 12'h320, '0, "R8");

        // R5 / R6: supervisor register gates U-mode, bit 3 hardwired
        csr_op(PS, 1'b1, 12'h120, 32'hFFFF_FFFF, "R5");
        csr_op(PS, 1'b0, 12'h120, '0, "R6");
        cnt_op(1'b1, PU, 0, "R5");
        cnt_op(1'b1, PU, 1, "R5");
        cnt_op(1'b1, PU, 2, "R5");
        cnt_op(1'b1, PU, 3, "R6");
        csr_op(PM, 1'b1, 12'h120, 32'hFFFF_FFFE, "R5");
        cnt_op(1'b1, PU, 0, "R5");
        cnt_op(1'b1, PU, 2, "R5");

        // R12: H-mode read in the instance without H
        cnt_op(1'b1, PH, 0, "R12");

        // R3: clearing machine bits cuts every lower mode
        csr_op(PM, 1'b1, 12'h320, 32'h0000_0000, "R3");
        cnt_op(1'b1, PU, 2, "R3");
        cnt_op(1'b1, PS, 0, "R3");
        cnt_op(1'b1, PH, 2, "R3");

        @(posedge clk);
        #1;
        csr_req = 1'b0;
        cnt_rd  = 1'b0;
        @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule